// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the parent side of an invalidation-style MSI coherence scheme. It owns the memory data for a small address space and serves a fixed number of child caches. For every address it records, per child, the state the child is believed to hold (I, S or M) and whether a downgrade to that child is still outstanding. Children send upgrade requests and downgrade responses on separate inbound valid/ready ports. The block answers on one outbound valid/ready port per child, which carries either an upgrade grant or a downgrade order.

When a request asks for a state that would clash with a sibling, the block does not grant it. It orders each clashing sibling to step down. It absorbs their answers, keeping dirty data only from children recorded in M. It grants the request once every sibling is compatible. The block handles one inbound message per cycle. Downgrade responses always win over requests, and requests are taken in round-robin order so that no child waits forever.

Back-pressure rules: an inbound message is consumed on a cycle where its valid and ready are both high. Ready may depend on valid, and a child must hold its message stable until it is consumed. An outbound message holds valid and all its fields until the child raises ready. The slot can be refilled on the same edge that consumes its previous message.

Top module: `hdir_home_ctrl`

## Requirements
- R1: After reset, no outbound message is valid, every child is recorded as I for every address, and every memory word reads as zero. State codes are I=0, S=1, M=2.
- R2: An upgrade request from child c to state y is consumed and answered with a grant (out_is_grant=1, out_state=y, out_addr = request address) in the cycle after consumption. This happens only when no sibling holds a state incompatible with y and no downgrade is outstanding for that address. M clashes with M and S, and every other pairing is compatible.
- R3: A grant carries memory data (out_has_data=1, out_data = memory word) only when the requester was recorded as I. An upgrade from S to M is granted with out_has_data=0.
- R4: For each sibling incompatible with a pending request, the block sends one downgrade order (out_is_grant=0) for that address and records it as outstanding. The target is I when M was requested and S when S was requested. The request stays unconsumed meanwhile.
- R5: While a child has an outstanding downgrade for an address, it receives no further downgrade order for that address, and no request for that address is granted.
- R6: A downgrade response from a child recorded in M writes its data into memory. A later grant for that address from I carries that data.
- R7: A downgrade response from a child not recorded in M leaves memory unchanged.
- R8: Downgrade responses are consumed even when nothing is outstanding. They set the child's entry to the carried state and clear the outstanding mark when its target is at or above the carried state.
- R9: At most one inbound message is consumed per cycle. A valid downgrade response is consumed ahead of any request in the same cycle, with the lowest-numbered child first.
- R10: Requests are examined in round-robin order, starting from child 0 after reset. After a request from child k is examined, child k+1 (wrapping to 0) has the highest priority.
- R11: An outbound message stays valid, with every field unchanged, until the child raises out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | Per-child upgrade request valid |
| req_ready | output | N | Per-child upgrade request consumed |
| req_addr | input | N*AW | Per-child request address |
| req_target | input | 2*N | Per-child requested state (S=1, M=2) |
| wb_valid | input | N | Per-child downgrade response valid |
| wb_ready | output | N | Per-child downgrade response consumed |
| wb_addr | input | N*AW | Per-child response address |
| wb_state | input | 2*N | Per-child state the child stepped down to |
| wb_data | input | N*DW | Per-child written-back data |
| out_valid | output | N | Per-child outbound message valid |
| out_ready | input | N | Per-child outbound message taken |
| out_is_grant | output | N | 1 = upgrade grant, 0 = downgrade order |
| out_addr | output | N*AW | Outbound message address |
| out_state | output | 2*N | Granted state or downgrade target |
| out_data | output | N*DW | Memory data for a grant |
| out_has_data | output | N | out_data is meaningful |

## Verification
The bench builds the block with its defaults: four children, eight addresses and eight-bit data. Four children are enough to clash one requester against two S holders at once, to show the round-robin pointer wrapping past the last child, and to keep unrelated children busy on other addresses. Eight addresses let each round-robin contender use its own address, so that order alone decides the grants.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } coh_e;

  // M cannot sit beside M or S; all other pairs may coexist.
  function automatic logic compat(input coh_e a, input coh_e b);
    if (a == ST_M && b != ST_I) return 1'b0;
    if (b == ST_M && a != ST_I) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/hdir_rr_pick.sv
module hdir_rr_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[(int'(start) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(start) + k) % N);
      end
    end
  end
endmodule

// File: rtl/hdir_sib_plan.sv
module hdir_sib_plan
  import hdir_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [2*N-1:0] row_st,
  input  logic [N-1:0]   row_pd,
  input  logic [IW-1:0]  who,
  input  coh_e           want,
  output logic           clear,
  output logic [N-1:0]   need,
  output coh_e           dg_to
);
  always_comb begin
    dg_to = (want == ST_M) ? ST_I : ST_S;
    clear = (row_pd == '0);
    need  = '0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) != who) begin
        if (!compat(coh_e'(row_st[2*i +: 2]), want)) begin
          clear = 1'b0;
          if (!row_pd[i]) need[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdir_out_slot.sv
module hdir_out_slot #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_grant,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_state,
  input  logic          ld_has,
  input  logic [DW-1:0] ld_data,
  input  logic          ready,
  output logic          valid,
  output logic          grant,
  output logic [AW-1:0] addr,
  output logic [1:0]    state,
  output logic          has,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      grant <= 1'b0;
      addr  <= '0;
      state <= '0;
      has   <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      grant <= ld_grant;
      addr  <= ld_addr;
      state <= ld_state;
      has   <= ld_has;
      data  <= ld_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || ready)); // R11

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(grant) && $stable(addr) &&
                           $stable(state) && $stable(has) && $stable(data))); // R11
endmodule

// File: rtl/hdir_home_ctrl.sv
module hdir_home_ctrl
  import hdir_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  output logic [N-1:0]    req_ready,
  input  logic [N*AW-1:0] req_addr,
  input  logic [2*N-1:0]  req_target,
  input  logic [N-1:0]    wb_valid,
  output logic [N-1:0]    wb_ready,
  input  logic [N*AW-1:0] wb_addr,
  input  logic [2*N-1:0]  wb_state,
  input  logic [N*DW-1:0] wb_data,
  output logic [N-1:0]    out_valid,
  input  logic [N-1:0]    out_ready,
  output logic [N-1:0]    out_is_grant,
  output logic [N*AW-1:0] out_addr,
  output logic [2*N-1:0]  out_state,
  output logic [N*DW-1:0] out_data,
  output logic [N-1:0]    out_has_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int A  = 1 << AW;

  logic [1:0]    dir_q  [N][A];
  logic          pend_v [N][A];
  logic [1:0]    pend_t [N][A];
  logic [DW-1:0] mem_q  [A];
  logic [IW-1:0] ptr_q;

  // inbound response selection: fixed priority, always first
  logic          rsp_any;
  logic [IW-1:0] wsel;
  hdir_rr_pick #(.N(N), .IW(IW)) u_wb_pick (
    .req(wb_valid), .start('0), .any(rsp_any), .idx(wsel));

  logic [AW-1:0] w_addr;
  logic [1:0]    w_state;
  logic [DW-1:0] w_data;
  assign w_addr  = wb_addr[int'(wsel)*AW +: AW];
  assign w_state = wb_state[int'(wsel)*2 +: 2];
  assign w_data  = wb_data[int'(wsel)*DW +: DW];

  // request selection: round-robin, only when no response is taken
  logic          rq_any;
  logic [IW-1:0] rsel;
  hdir_rr_pick #(.N(N), .IW(IW)) u_req_pick (
    .req(req_valid & {N{!rsp_any}}), .start(ptr_q), .any(rq_any), .idx(rsel));

  logic [AW-1:0] r_addr;
  coh_e          r_tgt;
  assign r_addr = req_addr[int'(rsel)*AW +: AW];
  assign r_tgt  = coh_e'(req_target[int'(rsel)*2 +: 2]);

  logic [2*N-1:0] row_st;
  logic [N-1:0]   row_pd;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      row_st[2*i +: 2] = dir_q[i][r_addr];
      row_pd[i]        = pend_v[i][r_addr];
    end
  end

  logic       sib_clear;
  logic [N-1:0] dg_need;
  coh_e       dg_to;
  hdir_sib_plan #(.N(N), .IW(IW)) u_plan (
    .row_st(row_st), .row_pd(row_pd), .who(rsel), .want(r_tgt),
    .clear(sib_clear), .need(dg_need), .dg_to(dg_to));

  logic [1:0]   own_st;
  logic         already;
  logic [N-1:0] slot_free;
  logic         do_grant;
  logic [N-1:0] dg_fire;
  assign own_st    = dir_q[rsel][r_addr];
  assign already   = (own_st >= 2'(r_tgt));
  assign slot_free = ~out_valid | out_ready;
  assign do_grant  = rq_any && (already || sib_clear) && slot_free[rsel];
  assign dg_fire   = (rq_any && !already) ? (dg_need & slot_free) : '0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_ready[i] = do_grant && (rsel == IW'(i));
      wb_ready[i]  = rsp_any && (wsel == IW'(i));
    end
  end

  // outbound slots, one per child
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic own;
    assign own = do_grant && (rsel == IW'(g));
    hdir_out_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(own || dg_fire[g]),
      .ld_grant(own),
      .ld_addr(r_addr),
      .ld_state(own ? 2'(r_tgt) : 2'(dg_to)),
      .ld_has(own && !already && (own_st == 2'(ST_I))),
      .ld_data(mem_q[r_addr]),
      .ready(out_ready[g]),
      .valid(out_valid[g]),
      .grant(out_is_grant[g]),
      .addr(out_addr[g*AW +: AW]),
      .state(out_state[2*g +: 2]),
      .has(out_has_data[g]),
      .data(out_data[g*DW +: DW]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        for (int a = 0; a < A; a++) begin
          dir_q[i][a]  <= 2'(ST_I);
          pend_v[i][a] <= 1'b0;
          pend_t[i][a] <= 2'(ST_I);
        end
      end
      for (int a = 0; a < A; a++) mem_q[a] <= '0;
      ptr_q <= '0;
    end else if (rsp_any) begin
      if (dir_q[wsel][w_addr] == 2'(ST_M)) mem_q[w_addr] <= w_data;
      dir_q[wsel][w_addr] <= w_state;
      if (pend_v[wsel][w_addr] && (pend_t[wsel][w_addr] >= w_state))
        pend_v[wsel][w_addr] <= 1'b0;
    end else if (rq_any) begin
      ptr_q <= (rsel == IW'(N-1)) ? '0 : IW'(rsel + 1'b1);
      if (do_grant && !already) dir_q[rsel][r_addr] <= 2'(r_tgt);
      for (int i = 0; i < N; i++) begin
        if (dg_fire[i]) begin
          pend_v[i][r_addr] <= 1'b1;
          pend_t[i][r_addr] <= 2'(dg_to);
        end
      end
    end
  end

  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wb_valid & wb_ready)) |-> ((req_valid & req_ready) == '0)); // R9

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid & req_ready)); // R10

  AST_DG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dg_fire) |-> ((dg_fire & row_pd) == '0)); // R5

  AST_GRANT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (do_grant && !already) |-> (row_pd == '0)); // R5

  for (genvar ga = 0; ga < A; ga++) begin : g_chk
    logic [N-1:0] m_bits;
    always_comb begin
      for (int i = 0; i < N; i++) m_bits[i] = (dir_q[i][ga] == 2'(ST_M));
    end
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(m_bits) <= 1); // R4
  end
endmodule

// File: tb/hdir_home_ctrl_bench.sv
module hdir_home_ctrl_bench;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int SI = 0, SS = 1, SM = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    req_valid;
  logic [N-1:0]    req_ready;
  logic [N*AW-1:0] req_addr;
  logic [2*N-1:0]  req_target;
  logic [N-1:0]    wb_valid;
  logic [N-1:0]    wb_ready;
  logic [N*AW-1:0] wb_addr;
  logic [2*N-1:0]  wb_state;
  logic [N*DW-1:0] wb_data;
  logic [N-1:0]    out_valid;
  logic [N-1:0]    out_ready;
  logic [N-1:0]    out_is_grant;
  logic [N*AW-1:0] out_addr;
  logic [2*N-1:0]  out_state;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    out_has_data;

  int n_chk = 0;
  int n_err = 0;
  int log_q [16];
  int lg_n;

  always #10 clk = ~clk;

  hdir_home_ctrl #(.N(N), .AW(AW), .DW(DW)) u_hdir_home_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_target(req_target),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_state(wb_state), .wb_data(wb_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_grant(out_is_grant),
    .out_addr(out_addr), .out_state(out_state), .out_data(out_data),
    .out_has_data(out_has_data));

  // drop inbound valids once consumed, and log grant order
  always @(posedge clk) begin
    if (!rst_n) lg_n <= 0;
    for (int i = 0; i < N; i++) begin
      if (rst_n && req_valid[i] && req_ready[i]) begin
        req_valid[i] <= 1'b0;
        log_q[lg_n % 16] <= i;
        lg_n <= lg_n + 1;
      end
      if (rst_n && wb_valid[i] && wb_ready[i]) wb_valid[i] <= 1'b0;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = '0; req_addr = '0; req_target = '0;
    wb_valid = '0; wb_addr = '0; wb_state = '0; wb_data = '0;
    out_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input int c, input int a, input int y);
    req_addr[c*AW +: AW] = AW'(a);
    req_target[c*2 +: 2] = 2'(y);
    req_valid[c] = 1'b1;
  endtask

  task automatic respond(input int c, input int a, input int y, input int d);
    wb_addr[c*AW +: AW] = AW'(a);
    wb_state[c*2 +: 2]  = 2'(y);
    wb_data[c*DW +: DW] = DW'(d);
    wb_valid[c] = 1'b1;
  endtask

  task automatic wait_accept(input int c, input string tag);
    for (int k = 0; k < 20 && req_valid[c]; k++) @(negedge clk);
    check_eq({tag, " request consumed"}, int'(!req_valid[c]), 1);
  endtask

  task automatic pop(input int c, input int kind, input int a, input int y,
                     input int hd, input int d, input string tag);
    for (int k = 0; k < 20 && !out_valid[c]; k++) @(negedge clk);
    check_eq({tag, " out_valid"}, int'(out_valid[c]), 1);
    check_eq({tag, " out_is_grant"}, int'(out_is_grant[c]), kind);
    check_eq({tag, " out_addr"}, int'(out_addr[c*AW +: AW]), a);
    check_eq({tag, " out_state"}, int'(out_state[c*2 +: 2]), y);
    if (kind == 1) check_eq({tag, " out_has_data"}, int'(out_has_data[c]), hd);
    if (hd == 1) check_eq({tag, " out_data"}, int'(out_data[c*DW +: DW]), d);
    out_ready[c] = 1'b1;
    @(negedge clk);
    out_ready[c] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1 no outbound after reset", int'(out_valid), 0);
    check_eq("R1 no request ready when idle", int'(req_ready), 0);
    check_eq("R9 no response ready when idle", int'(wb_ready), 0);
  endtask

  task automatic t_read_grant();
    do_reset();
    issue(0, 3, SS);
    wait_accept(0, "R2");
    pop(0, 1, 3, SS, 1, 0, "R1 R2 first grant from I with zero data");
    issue(0, 3, SM);
    wait_accept(0, "R3");
    pop(0, 1, 3, SM, 0, 0, "R3 S to M grant without data");
  endtask

  task automatic t_dirty_recall();
    do_reset();
    issue(0, 5, SM);
    wait_accept(0, "R2");
    pop(0, 1, 5, SM, 1, 0, "R2 M grant");
    issue(1, 5, SS);
    pop(0, 0, 5, SS, 0, 0, "R4 downgrade to S for S request");
    repeat (3) @(negedge clk);
    check_eq("R4 request held during downgrade", int'(req_valid[1]), 1);
    check_eq("R5 no second downgrade while outstanding", int'(out_valid[0]), 0);
    respond(0, 5, SS, 8'hA5);
    wait_accept(1, "R6");
    pop(1, 1, 5, SS, 1, 8'hA5, "R6 grant carries written-back data");
  endtask

  task automatic t_write_clash();
    do_reset();
    issue(0, 2, SS);
    wait_accept(0, "R2");
    pop(0, 1, 2, SS, 1, 0, "R2 S grant child 0");
    issue(1, 2, SS);
    wait_accept(1, "R2");
    pop(1, 1, 2, SS, 1, 0, "R2 S grant beside S sibling");
    issue(2, 2, SM);
    pop(0, 0, 2, SI, 0, 0, "R4 downgrade child 0 to I");
    pop(1, 0, 2, SI, 0, 0, "R4 downgrade child 1 to I");
    check_eq("R5 M request held while outstanding", int'(req_valid[2]), 1);
    respond(0, 2, SI, 8'h11);
    respond(1, 2, SI, 8'h22);
    wait_accept(2, "R5");
    pop(2, 1, 2, SM, 1, 0, "R7 S holders do not write memory");
  endtask

  task automatic t_voluntary();
    do_reset();
    issue(0, 1, SS);
    wait_accept(0, "R2");
    pop(0, 1, 1, SS, 1, 0, "R2 S grant");
    respond(0, 1, SI, 8'h77);
    @(negedge clk);
    check_eq("R8 voluntary response consumed", int'(wb_valid[0]), 0);
    issue(1, 1, SM);
    wait_accept(1, "R8");
    pop(1, 1, 1, SM, 1, 0, "R7 R8 M grant with unchanged memory");
    check_eq("R8 no downgrade to the child that left", int'(out_valid[0]), 0);
  endtask

  task automatic t_priority();
    do_reset();
    issue(0, 4, SM);
    wait_accept(0, "R2");
    pop(0, 1, 4, SM, 1, 0, "R2 M grant");
    respond(0, 4, SI, 8'h3C);
    issue(1, 6, SS);
    @(negedge clk);
    check_eq("R9 response consumed first", int'(wb_valid[0]), 0);
    check_eq("R9 request waits behind response", int'(req_valid[1]), 1);
    wait_accept(1, "R9");
    pop(1, 1, 6, SS, 1, 0, "R9 late request grant");
    issue(2, 4, SS);
    wait_accept(2, "R6");
    pop(2, 1, 4, SS, 1, 8'h3C, "R6 voluntary dirty write-back kept");
  endtask

  task automatic t_round_robin();
    do_reset();
    issue(1, 0, SS);
    wait_accept(1, "R10");
    pop(1, 1, 0, SS, 1, 0, "R10 lone grant");
    for (int c = 0; c < N; c++) issue(c, c + 1, SS);
    for (int c = 0; c < N; c++) wait_accept(c, "R10");
    check_eq("R10 order slot 1", log_q[1], 2);
    check_eq("R10 order slot 2", log_q[2], 3);
    check_eq("R10 order slot 3", log_q[3], 0);
    check_eq("R10 order slot 4", log_q[4], 1);
    for (int c = 0; c < N; c++) pop(c, 1, c + 1, SS, 1, 0, "R10 grant");
  endtask

  task automatic t_hold();
    do_reset();
    issue(3, 7, SS);
    wait_accept(3, "R11");
    repeat (3) @(negedge clk);
    check_eq("R11 held valid", int'(out_valid[3]), 1);
    check_eq("R11 held addr", int'(out_addr[3*AW +: AW]), 7);
    pop(3, 1, 7, SS, 1, 0, "R11 held grant");
    check_eq("R11 released after ready", int'(out_valid[3]), 0);
  endtask

  initial begin
    t_reset();
    t_read_grant();
    t_dirty_recall();
    t_write_clash();
    t_voluntary();
    t_priority();
    t_round_robin();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule